// File: doc/BRIEF.md
# Two-Level Segmented Page Table Walker

This block resolves a translation miss by fetching two levels of tables from memory. A 32-bit virtual address is split three ways. The top four bits choose a segment. The next sixteen bits choose a page within that segment. The low twelve bits are the byte offset inside a 4 KB page, and they are never translated. The segment number indexes a first-level table whose base address is given by a table-base input. The selected first-level entry gives the location of a second-level table and the number of pages the segment holds. The page number indexes that second-level table, and the entry found there supplies the physical page number.

The walker accepts one miss at a time. It issues its reads one after another over a memory port that has at most one read outstanding. When the walk ends it gives a single-cycle completion with a status code and either the translated physical address or zero. A page index that falls outside the segment's page count is reported as a segment fault. A missing first-level mapping is also reported as a segment fault. A missing second-level mapping is reported as a page fault.

Top module: `seg_page_walker`

## Requirements
- R1: After reset `missReady` is 1, and `memReqValid` and `doneValid` are 0.
- R2: A miss is taken in a cycle where `missValid` and `missReady` are both 1. `missVaddr` and `tableBase` are captured in that cycle. In the next cycle `memReqValid` rises with `memReqAddr` = `tableBase` + 4 × `missVaddr[31:28]`.
- R3: `memReqValid` and `memReqAddr` stay unchanged until the cycle in which `memRespValid` is 1. `memReqValid` is never high while `missReady` is high.
- R4: A first-level word carries the valid flag in bit 0, a table pointer in 4 KB units in bits 15:1, and a page count in bits 31:16. A first-level word with bit 0 clear ends the walk after one read with status 2'b10 (segment fault).
- R5: The page index is `missVaddr[27:12]`. When it is not below the page count, the walk ends after one read with status 2'b10. A count of zero therefore always faults, and index = count − 1 is translated.
- R6: The second read goes to (pointer × 4096) + 4 × page index.
- R7: A second-level word carries the valid flag in bit 0 and the physical page number in bits 31:12. When bit 0 is clear, the walk ends with status 2'b01 (page fault).
- R8: On success the status is 2'b00 and `donePaddr` = {physical page number, `missVaddr[11:0]`}.
- R9: `doneValid` is high for exactly one cycle per walk, and `missReady` is high in the following cycle. The status is never 2'b11. On either fault `donePaddr` is zero.
- R10: While a walk is in progress, `missValid` and `missVaddr` have no effect, and the result belongs to the miss that was taken.
- R11: Changes on `tableBase` after a miss has been taken do not alter that walk's read addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | Translation miss request |
| missVaddr | input | 32 | Virtual address of the miss |
| tableBase | input | 32 | Byte address of the first-level table |
| missReady | output | 1 | Walker idle and able to take a miss |
| memReqValid | output | 1 | Memory read request, held until answered |
| memReqAddr | output | 32 | Byte address of the word to read |
| memRespValid | input | 1 | Read data valid this cycle |
| memRespData | input | 32 | Read data word |
| doneValid | output | 1 | One-cycle completion strobe |
| doneStatus | output | 2 | 00 ok, 01 page fault, 10 segment fault |
| donePaddr | output | 32 | Physical address on success, zero on fault |

## Verification
The bench walks the edges of the bounds check. It translates the last page of a segment, faults the page just past it, and faults a segment with a count of zero. A walker that used less-or-equal or signed compares would translate a page it must refuse. It uses a segment with both count and pointer at their maximum, and a second-level word that holds a page number but has its valid flag clear. Truncated address arithmetic, or a valid flag taken from the wrong bit, would then show up as a wrong read address or status. During a walk it drives a new miss and moves the table base. A walker that re-sampled either input would read from a shifted address or report the wrong translation.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_CHECK_L1,
    ST_READ_L2,
    ST_CHECK_L2,
    ST_DONE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchMiss;   // capture miss address and table base
    logic capEntry;    // capture the returned table word
    logic selL2;       // drive the second-level address
    logic loadResult;  // commit the translated address
  } walkStrobe_t;

  localparam logic [1:0] STAT_OK        = 2'b00;
  localparam logic [1:0] STAT_PAGE_FLT  = 2'b01;
  localparam logic [1:0] STAT_SEG_FLT   = 2'b10;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memRespValid,
  input  logic        entryValid,
  input  logic        pageInRange,
  output walkStrobe_t strb,
  output logic        missReady,
  output logic        memReqValid,
  output logic        doneValid,
  output logic [1:0]  doneStatus
);

  walkState_t state, stateNext;
  logic [1:0] statusReg, statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      statusReg <= STAT_OK;
    end else begin
      state     <= stateNext;
      statusReg <= statusNext;
    end
  end

  always_comb begin
    stateNext  = state;
    statusNext = statusReg;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (missValid) begin
          strb.latchMiss = 1'b1;
          stateNext      = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        if (memRespValid) begin
          strb.capEntry = 1'b1;
          stateNext     = ST_CHECK_L1;
        end
      end
      ST_CHECK_L1: begin
        if (!entryValid || !pageInRange) begin
          statusNext = STAT_SEG_FLT;
          stateNext  = ST_DONE;
        end else begin
          stateNext  = ST_READ_L2;
        end
      end
      ST_READ_L2: begin
        strb.selL2 = 1'b1;
        if (memRespValid) begin
          strb.capEntry = 1'b1;
          stateNext     = ST_CHECK_L2;
        end
      end
      ST_CHECK_L2: begin
        if (entryValid) begin
          statusNext      = STAT_OK;
          strb.loadResult = 1'b1;
        end else begin
          statusNext = STAT_PAGE_FLT;
        end
        stateNext = ST_DONE;
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  assign missReady   = (state == ST_IDLE);
  assign memReqValid = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign doneValid   = (state == ST_DONE);
  assign doneStatus  = statusReg;

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SEG_W  = 4,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walkStrobe_t             strb,
  input  logic [VA_W-1:0]         missVaddr,
  input  logic [ADDR_W-1:0]       tableBase,
  input  logic [WORD_W-1:0]       memRespData,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic                    entryValid,
  output logic                    pageInRange,
  output logic [VA_W-1:0]         donePaddr
);

  localparam int PAGE_W      = VA_W - OFF_W - SEG_W;
  localparam int PTR_W       = WORD_W - CNT_W - 1;
  localparam int PPN_W       = WORD_W - OFF_W;
  localparam int ENTRY_SHIFT = $clog2(WORD_W / 8);
  localparam int CMP_W       = (PAGE_W > CNT_W) ? PAGE_W : CNT_W;

  logic [VA_W-1:0]   vaReg;
  logic [ADDR_W-1:0] baseReg;
  logic [WORD_W-1:0] entryReg;   // shared between both table levels
  logic [VA_W-1:0]   resultReg;

  logic [SEG_W-1:0]  segIdx;
  logic [PAGE_W-1:0] pageIdx;
  logic [OFF_W-1:0]  pageOff;
  logic [CNT_W-1:0]  pageCount;
  logic [PTR_W-1:0]  tablePtr;
  logic [PPN_W-1:0]  leafPpn;
  logic [ADDR_W-1:0] l1Addr;
  logic [ADDR_W-1:0] l2Addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg     <= '0;
      baseReg   <= '0;
      entryReg  <= '0;
      resultReg <= '0;
    end else begin
      if (strb.latchMiss) begin
        vaReg     <= missVaddr;
        baseReg   <= tableBase;
        resultReg <= '0;
      end
      if (strb.capEntry) begin
        entryReg <= memRespData;
      end
      if (strb.loadResult) begin
        resultReg <= {leafPpn, pageOff};
      end
    end
  end

  assign segIdx   = vaReg[VA_W-1 -: SEG_W];
  assign pageIdx  = vaReg[OFF_W +: PAGE_W];
  assign pageOff  = vaReg[OFF_W-1:0];

  // field views of the held table word
  assign entryValid = entryReg[0];
  assign tablePtr   = entryReg[PTR_W:1];
  assign pageCount  = entryReg[WORD_W-1 -: CNT_W];
  assign leafPpn    = entryReg[WORD_W-1 -: PPN_W];

  assign l1Addr = baseReg + (ADDR_W'(segIdx) << ENTRY_SHIFT);
  assign l2Addr = (ADDR_W'(tablePtr) << OFF_W) + (ADDR_W'(pageIdx) << ENTRY_SHIFT);

  assign memReqAddr  = strb.selL2 ? l2Addr : l1Addr;
  assign pageInRange = CMP_W'(pageIdx) < CMP_W'(pageCount);
  assign donePaddr   = resultReg;

endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
  import walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SEG_W  = 4,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [VA_W-1:0]   missVaddr,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              missReady,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [WORD_W-1:0] memRespData,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [VA_W-1:0]   donePaddr
);

  walkStrobe_t strb;
  logic        entryValid;
  logic        pageInRange;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memRespValid(memRespValid),
    .entryValid  (entryValid),
    .pageInRange (pageInRange),
    .strb        (strb),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .doneValid   (doneValid),
    .doneStatus  (doneStatus)
  );

  walk_datapath #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .SEG_W (SEG_W),
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .missVaddr  (missVaddr),
    .tableBase  (tableBase),
    .memRespData(memRespData),
    .memReqAddr (memReqAddr),
    .entryValid (entryValid),
    .pageInRange(pageInRange),
    .donePaddr  (donePaddr)
  );

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int VA_W   = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              missReady,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRespValid,
  input logic              doneValid,
  input logic [1:0]        doneStatus,
  input logic [VA_W-1:0]   donePaddr
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> missReady && !memReqValid && !doneValid);

  assert_walk_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> (memReqValid && !missReady));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRespValid) |=> (memReqValid && $stable(memReqAddr)));

  assert_no_req_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && missReady));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && missReady));

  assert_status_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneStatus != 2'b11));

  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && (doneStatus != 2'b00)) |-> (donePaddr == '0));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (!memReqValid && !missReady));

endmodule

bind seg_page_walker walk_checker #(.VA_W(VA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .missValid   (missValid),
  .missReady   (missReady),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRespValid(memRespValid),
  .doneValid   (doneValid),
  .doneStatus  (doneStatus),
  .donePaddr   (donePaddr)
);

// File: tb/seg_page_walker_tb.sv
module seg_page_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missVaddr = '0;
  logic [31:0] tableBase = '0;
  logic        missReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRespValid;
  logic [31:0] memRespData;
  logic        doneValid;
  logic [1:0]  doneStatus;
  logic [31:0] donePaddr;

  always #4 clk = ~clk;   // 125 MHz

  seg_page_walker u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missVaddr(missVaddr),
    .tableBase(tableBase), .missReady(missReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid), .memRespData(memRespData),
    .doneValid(doneValid), .doneStatus(doneStatus), .donePaddr(donePaddr)
  );

  int nVec = 0;
  int nBad = 0;

  logic [31:0] memModel [logic [31:0]];
  logic [31:0] expAddr [2];
  int          expReads = 0;
  int          readIdx  = 0;
  int          reqSeen  = 0;
  bit          walkActive = 0;
  bit          armed = 0;
  int          waitCnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (memModel.exists(a)) return memModel[a];
    return 32'h0;
  endfunction

  // behavioural reference of one walk
  task automatic predict(input logic [31:0] va, input logic [31:0] base,
                         output logic [1:0] st, output logic [31:0] pa,
                         output logic [31:0] a1, output logic [31:0] a2, output int nr);
    logic [31:0] e1, e2;
    int unsigned seg, page, cnt;
    seg  = va[31:28];
    page = va[27:12];
    a1 = base + seg * 4;
    e1 = rd(a1);
    cnt = e1[31:16];
    a2 = '0;
    nr = 1;
    if (!e1[0] || page >= cnt) begin
      st = 2'b10; pa = '0;
    end else begin
      a2 = {5'b0, e1[15:1], 12'b0} + page * 4;
      e2 = rd(a2);
      nr = 2;
      if (!e2[0]) begin st = 2'b01; pa = '0; end
      else begin st = 2'b00; pa = {e2[31:12], va[11:0]}; end
    end
  endtask

  // memory responder: one read at a time, latency 1..3 cycles
  initial begin
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk);
      memRespValid = 1'b0;
      if (memReqValid) begin
        if (!armed) begin
          armed   = 1;
          waitCnt = 1 + (reqSeen % 3);
          reqSeen++;
          check(walkActive && readIdx < expReads, "R3 unexpected read", readIdx, expReads);
        end
        if (readIdx < 2)
          check(memReqAddr == expAddr[readIdx], (readIdx == 0) ? "R2 first-level address" : "R6 second-level address",
                memReqAddr, expAddr[readIdx]);
        waitCnt--;
        if (waitCnt == 0) begin
          memRespValid = 1'b1;
          memRespData  = rd(memReqAddr);
          armed = 0;
          readIdx++;
        end
      end
    end
  end

  // stray completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && doneValid && !walkActive) check(1'b0, "R9 stray done", 32'd1, 32'd0);
    end
  end

  task automatic runWalk(input logic [31:0] va, input logic [31:0] base, input bit noise, input string tag);
    logic [1:0]  eSt;
    logic [31:0] ePa, a1, a2;
    int nr, cnt;
    predict(va, base, eSt, ePa, a1, a2, nr);
    expAddr[0] = a1; expAddr[1] = a2; expReads = nr; readIdx = 0;
    @(negedge clk);
    while (!missReady) @(negedge clk);
    walkActive = 1;
    missValid = 1'b1; missVaddr = va; tableBase = base;
    @(negedge clk);
    missValid = 1'b0;
    if (noise) begin
      for (int i = 0; i < 2; i++) begin
        check(missReady == 1'b0, "R10 ready low while busy", {31'b0, missReady}, 32'd0);
        missValid = 1'b1;
        missVaddr = va ^ 32'hF000_0FF0;
        tableBase = base + 32'h100;   // R11: late base change
        @(negedge clk);
      end
      missValid = 1'b0;
    end
    cnt = 0;
    while (!doneValid && cnt < 100) begin @(negedge clk); cnt++; end
    check(doneValid, {tag, " done seen"}, {31'b0, doneValid}, 32'd1);
    check(doneStatus == eSt, {tag, " status"}, {30'b0, doneStatus}, {30'b0, eSt});
    check(donePaddr == ePa, {tag, " paddr"}, donePaddr, ePa);
    check(readIdx == nr, {tag, " read count"}, readIdx, nr);
    @(negedge clk);
    walkActive = 0;
    check(!doneValid && missReady, "R9 one-cycle done then ready", {30'b0, doneValid, missReady}, 32'd1);
  endtask

  localparam logic [31:0] B0 = 32'h0010_0000;
  localparam logic [31:0] B1 = 32'h0040_0000;

  initial begin
    repeat (50000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    // first-level entries: {count, ptr[14:0], valid}
    memModel[B0 + 4]    = {16'd8,     15'h0200, 1'b1};
    memModel[B0 + 8]    = {16'd8,     15'h0300, 1'b0};
    memModel[B0 + 12]   = {16'd0,     15'h0400, 1'b1};
    memModel[B0 + 60]   = {16'hFFFF,  15'h7FFF, 1'b1};
    memModel[B1]        = {16'd1,     15'h0010, 1'b1};
    // second-level entries: {ppn, 11'b0, valid}
    memModel[32'h0020_000C] = {20'hABCDE, 11'h0, 1'b1};
    memModel[32'h0020_001C] = {20'h12345, 11'h0, 1'b1};
    memModel[32'h0020_0014] = {20'h55555, 11'h0, 1'b0};
    memModel[32'h0803_EFF8] = {20'hFFFFF, 11'h0, 1'b1};
    memModel[32'h0001_0000] = {20'h00001, 11'h0, 1'b1};

    repeat (3) @(negedge clk);
    check(missReady && !memReqValid && !doneValid, "R1 reset state",
          {29'b0, missReady, memReqValid, doneValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(missReady && !memReqValid && !doneValid, "R1 idle after reset",
          {29'b0, missReady, memReqValid, doneValid}, 32'h4);

    runWalk(32'h1000_3ABC, B0, 0, "R8 seg1 page3 translate");
    runWalk(32'h1000_7001, B0, 0, "R5 last page of segment");
    runWalk(32'h1000_8123, B0, 0, "R5 page equal to count");
    runWalk(32'h1000_5FFF, B0, 0, "R7 invalid leaf");
    runWalk(32'h1000_4000, B0, 0, "R7 unmapped leaf");
    runWalk(32'h2000_0000, B0, 0, "R4 invalid segment");
    runWalk(32'h3000_0456, B0, 0, "R5 zero-count segment");
    runWalk(32'hFFFF_EFFF, B0, 1, "R10 R11 max segment with noise");
    runWalk(32'hFFFF_F000, B0, 0, "R5 page at max count");
    runWalk(32'h0000_0A5A, B1, 0, "R2 second table base");
    runWalk(32'h1000_3000, B0, 1, "R6 R11 repeat with noise");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule